// File: doc/BRIEF.md
# Precision Time Protocol Frame Classifier

This block taps a byte-wide frame stream, one byte per accepted cycle, and decides while the frame passes whether it carries a precision time protocol (PTP) message. When it does, it also reports the frame byte index where the PTP header starts. It steps through the layers in turn: the MAC addresses, any stacked 802.1Q or provider tags, a backbone service-instance tag with its inner MAC pair, an MPLS label stack, and an IPv4/UDP or IPv6/UDP wrapper. The same block serves the transmit path or the receive path, since it only observes the bytes.

The block is a passive observer. It holds no byte and drives no ready signal, so it never applies back-pressure. The upstream source stalls by lowering `in_valid`, and a stalled cycle has no effect on the parse. `in_sof` marks the first byte of a frame and is only read together with `in_valid`. The verdict comes out once the second PTP header byte has been accepted, which is well before the rest of the header has passed. The verdict fields then hold their values until the next frame starts.

Top module: `ptp_event_classifier`

## Requirements
- R1: After reset, `o_hit` and `o_strobe` are 0 and remain 0 until a frame is classified.
- R2: A frame with EtherType 0x88F7 straight after the 12 MAC address bytes is a hit with offset 14. The message type is the low nibble of header byte 0, and the version is the low nibble of header byte 1.
- R3: Each 4-byte tag whose first two bytes are 0x8100 or 0x88A8 is skipped, and the two bytes after it are read as the next EtherType. Tags may be stacked.
- R4: A 0x88E7 service tag is skipped together with its 4 tag bytes and the 12 inner MAC bytes that follow it. The next two bytes are then read as an EtherType.
- R5: For EtherType 0x0800, the first IP byte must carry version nibble 4 and a length nibble of at least 5, and IP byte 9 must be 17. UDP then starts at 4 times that length nibble. Any other protocol value is no hit.
- R6: For EtherType 0x86DD, the first IP byte must carry version nibble 6 and IP byte 6 must be 17. UDP then starts 40 bytes in. Any other next-header value is no hit.
- R7: After UDP, a destination port of 319 sets `o_event` to 1 and a port of 320 sets it to 0. The PTP header follows the 8-byte UDP header. Any other port is no hit.
- R8: For EtherType 0x8847, 4-byte labels are skipped until one has bit 0 of its third byte set. The high nibble of the next byte then selects the IPv4 path (4) or the IPv6 path (6), and any other value is no hit.
- R9: A hit requires a version nibble of 1 or 2. Any other version is no hit.
- R10: `o_strobe` is high for exactly one cycle, in the cycle after header byte 1 is accepted. `o_hit` and the result fields hold until a start-of-frame byte is accepted, and `o_hit` is 0 from the following cycle on.
- R11: A cycle with `in_valid` low advances no parse state, so gaps inside a frame do not change the result.
- R12: A frame with any other EtherType is no hit, and `o_strobe` stays 0 for it.
- R13: A start-of-frame byte restarts the parse at frame byte 0, whatever state the previous frame left behind.
- R14: Without UDP, `o_event` is 1 when bit 3 of the message type is 0, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A byte is present on in_data this cycle |
| in_sof | input | 1 | The present byte is frame byte 0 |
| in_data | input | 8 | Frame byte |
| o_strobe | output | 1 | One-cycle pulse when a PTP header is found |
| o_hit | output | 1 | The current frame holds a PTP header |
| o_event | output | 1 | The message is of the event class |
| o_msg_type | output | 4 | Message type nibble |
| o_version | output | 4 | Version nibble |
| o_hdr_ofs | output | OFFW | Frame byte index of PTP header byte 0 |

## Verification
The hardest situations to reach from the ports are deep stacks: a service tag followed by a customer tag and IPv4, and a two-label MPLS stack whose bottom label hands over to IPv6. In both, the header offset depends on every layer being counted exactly. The bench builds each frame from a descriptor that names its layers, then checks the offset and the cycle of the strobe against hand-derived values. Every other frame is sent with idle gaps. A frame is also cut off mid-IPv4 by a new start-of-frame byte, to show that the parse restarts cleanly.

// File: rtl/ptp_cls_pkg.sv
package ptp_cls_pkg;
  localparam int POSW = 6;
  localparam logic [15:0] ET_PTP    = 16'h88F7;
  localparam logic [15:0] ET_CTAG   = 16'h8100;
  localparam logic [15:0] ET_STAG   = 16'h88A8;
  localparam logic [15:0] ET_ISVC   = 16'h88E7;
  localparam logic [15:0] ET_IPV4   = 16'h0800;
  localparam logic [15:0] ET_IPV6   = 16'h86DD;
  localparam logic [15:0] ET_MPLS   = 16'h8847;
  localparam logic [15:0] PORT_EVT  = 16'd319;
  localparam logic [15:0] PORT_GEN  = 16'd320;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam int MAC_BYTES  = 12;
  localparam int ISVC_BYTES = 16;
  localparam int IP6_BYTES  = 40;
  localparam int UDP_BYTES  = 8;

  typedef enum logic [3:0] {
    ST_MAC, ST_ETYPE, ST_TAG, ST_ISVC, ST_MPLS, ST_MPLS_SEL,
    ST_IP4, ST_IP6, ST_UDP, ST_PTP, ST_DONE, ST_DROP
  } walk_st_e;
endpackage

// File: rtl/ptp_byte_tracker.sv
module ptp_byte_tracker #(
  parameter int OFFW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [7:0]      in_data,
  output logic [OFFW-1:0] cur_idx,
  output logic [7:0]      prev_byte
);
  localparam logic [OFFW-1:0] IDX_MAX = '1;

  logic [OFFW-1:0] idx_q;

  assign cur_idx = in_sof ? '0 : idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx_q     <= IDX_MAX;
      prev_byte <= 8'h00;
    end else if (in_valid) begin
      prev_byte <= in_data;
      if (cur_idx != IDX_MAX) idx_q <= cur_idx + 1'b1;
    end
  end

  p_idx_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (idx_q == OFFW'(1)));
endmodule

// File: rtl/ptp_layer_walker.sv
module ptp_layer_walker
  import ptp_cls_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_data,
  input  logic [7:0] prev_byte,
  output logic       hdr_b0,
  output logic       hdr_b1,
  output logic       via_udp,
  output logic       udp_evt
);
  walk_st_e         st_q, eff_st, nxt_st;
  logic [POSW-1:0]  pos_q, eff_pos, nxt_pos;
  logic [3:0]       ihl_q, nxt_ihl;
  logic             bos_q, nxt_bos;
  logic             udp_q, nxt_udp, evt_q, nxt_evt;
  logic             b0, b1;
  logic [15:0]      word;

  assign word = {prev_byte, in_data};

  always_comb begin
    eff_st  = st_q;
    eff_pos = pos_q;
    nxt_udp = udp_q;
    nxt_evt = evt_q;
    if (in_sof) begin
      eff_st  = ST_MAC;
      eff_pos = '0;
      nxt_udp = 1'b0;
    end else if (st_q == ST_MPLS_SEL) begin
      eff_pos = '0;
      if (in_data[7:4] == 4'd4)      eff_st = ST_IP4;
      else if (in_data[7:4] == 4'd6) eff_st = ST_IP6;
      else                           eff_st = ST_DROP;
    end

    nxt_st  = eff_st;
    nxt_ihl = ihl_q;
    nxt_bos = bos_q;
    b0      = 1'b0;
    b1      = 1'b0;

    case (eff_st)
      ST_MAC: if (eff_pos == POSW'(MAC_BYTES - 1)) nxt_st = ST_ETYPE;
      ST_ETYPE: begin
        if (eff_pos == POSW'(1)) begin
          case (word)
            ET_PTP:           nxt_st = ST_PTP;
            ET_CTAG, ET_STAG: nxt_st = ST_TAG;
            ET_ISVC:          nxt_st = ST_ISVC;
            ET_IPV4:          nxt_st = ST_IP4;
            ET_IPV6:          nxt_st = ST_IP6;
            ET_MPLS:          nxt_st = ST_MPLS;
            default:          nxt_st = ST_DROP;
          endcase
        end
      end
      ST_TAG:  if (eff_pos == POSW'(1)) nxt_st = ST_ETYPE;
      ST_ISVC: if (eff_pos == POSW'(ISVC_BYTES - 1)) nxt_st = ST_ETYPE;
      ST_MPLS: begin
        if (eff_pos[1:0] == 2'd2) nxt_bos = in_data[0];
        if (eff_pos[1:0] == 2'd3 && bos_q) nxt_st = ST_MPLS_SEL;
      end
      ST_IP4: begin
        if (eff_pos == '0) begin
          if (in_data[7:4] != 4'd4 || in_data[3:0] < 4'd5) nxt_st = ST_DROP;
          nxt_ihl = in_data[3:0];
        end else if (eff_pos == POSW'(9)) begin
          if (in_data != PROTO_UDP) nxt_st = ST_DROP;
        end else if (eff_pos > POSW'(9) &&
                     eff_pos == ({ihl_q, 2'b00} - POSW'(1))) begin
          nxt_st = ST_UDP;
        end
      end
      ST_IP6: begin
        if (eff_pos == '0) begin
          if (in_data[7:4] != 4'd6) nxt_st = ST_DROP;
        end else if (eff_pos == POSW'(6)) begin
          if (in_data != PROTO_UDP) nxt_st = ST_DROP;
        end else if (eff_pos == POSW'(IP6_BYTES - 1)) begin
          nxt_st = ST_UDP;
        end
      end
      ST_UDP: begin
        if (eff_pos == POSW'(3)) begin
          if (word == PORT_EVT) begin
            nxt_udp = 1'b1;
            nxt_evt = 1'b1;
          end else if (word == PORT_GEN) begin
            nxt_udp = 1'b1;
            nxt_evt = 1'b0;
          end else begin
            nxt_st = ST_DROP;
          end
        end else if (eff_pos == POSW'(UDP_BYTES - 1)) begin
          nxt_st = ST_PTP;
        end
      end
      ST_PTP: begin
        if (eff_pos == '0) begin
          b0 = 1'b1;
        end else begin
          b1     = 1'b1;
          nxt_st = ST_DONE;
        end
      end
      default: nxt_st = eff_st;
    endcase

    nxt_pos = (nxt_st != eff_st) ? '0 : eff_pos + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_DROP;
      pos_q <= '0;
      ihl_q <= 4'd5;
      bos_q <= 1'b0;
      udp_q <= 1'b0;
      evt_q <= 1'b0;
    end else if (in_valid) begin
      st_q  <= nxt_st;
      pos_q <= nxt_pos;
      ihl_q <= nxt_ihl;
      bos_q <= nxt_bos;
      udp_q <= nxt_udp;
      evt_q <= nxt_evt;
    end
  end

  assign hdr_b0  = in_valid && b0;
  assign hdr_b1  = in_valid && b1;
  assign via_udp = udp_q;
  assign udp_evt = evt_q;

  p_gap_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(st_q) && $stable(pos_q)));
  p_sof_restart_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_sof) |=> (st_q == ST_MAC && pos_q == POSW'(1)));
endmodule

// File: rtl/ptp_result_hold.sv
module ptp_result_hold #(
  parameter int OFFW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [3:0]      in_nib,
  input  logic [OFFW-1:0] cur_idx,
  input  logic            hdr_b0,
  input  logic            hdr_b1,
  input  logic            via_udp,
  input  logic            udp_evt,
  output logic            o_strobe,
  output logic            o_hit,
  output logic            o_event,
  output logic [3:0]      o_msg_type,
  output logic [3:0]      o_version,
  output logic [OFFW-1:0] o_hdr_ofs
);
  logic [OFFW-1:0] ofs_cap;
  logic [3:0]      mt_cap;
  logic            ver_ok;

  assign ver_ok = (in_nib == 4'd1) || (in_nib == 4'd2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ofs_cap    <= '0;
      mt_cap     <= '0;
      o_strobe   <= 1'b0;
      o_hit      <= 1'b0;
      o_event    <= 1'b0;
      o_msg_type <= '0;
      o_version  <= '0;
      o_hdr_ofs  <= '0;
    end else begin
      o_strobe <= 1'b0;
      if (in_valid && in_sof) o_hit <= 1'b0;
      if (hdr_b0) begin
        ofs_cap <= cur_idx;
        mt_cap  <= in_nib;
      end
      if (hdr_b1 && ver_ok) begin
        o_strobe   <= 1'b1;
        o_hit      <= 1'b1;
        o_msg_type <= mt_cap;
        o_version  <= in_nib;
        o_hdr_ofs  <= ofs_cap;
        o_event    <= via_udp ? udp_evt : !mt_cap[3];
      end
    end
  end

  p_strobe_hit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    o_strobe |-> o_hit);
  p_rise_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(o_hit) |-> o_strobe);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (o_hit && !o_strobe) |-> ($stable(o_hdr_ofs) && $stable(o_msg_type) && $stable(o_version)));
  p_ver_ok_r9: assert property (@(posedge clk) disable iff (!rst_n)
    o_hit |-> (o_version == 4'd1 || o_version == 4'd2));
  p_ofs_min_r2: assert property (@(posedge clk) disable iff (!rst_n)
    o_hit |-> (o_hdr_ofs >= OFFW'(14)));
endmodule

// File: rtl/ptp_event_classifier.sv
module ptp_event_classifier #(
  parameter int OFFW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [7:0]      in_data,
  output logic            o_strobe,
  output logic            o_hit,
  output logic            o_event,
  output logic [3:0]      o_msg_type,
  output logic [3:0]      o_version,
  output logic [OFFW-1:0] o_hdr_ofs
);
  logic [OFFW-1:0] cur_idx;
  logic [7:0]      prev_byte;
  logic            hdr_b0, hdr_b1, via_udp, udp_evt;

  ptp_byte_tracker #(.OFFW(OFFW)) u_track (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .cur_idx(cur_idx), .prev_byte(prev_byte)
  );

  ptp_layer_walker u_walk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .prev_byte(prev_byte), .hdr_b0(hdr_b0),
    .hdr_b1(hdr_b1), .via_udp(via_udp), .udp_evt(udp_evt)
  );

  ptp_result_hold #(.OFFW(OFFW)) u_res (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_nib(in_data[3:0]), .cur_idx(cur_idx), .hdr_b0(hdr_b0),
    .hdr_b1(hdr_b1), .via_udp(via_udp), .udp_evt(udp_evt),
    .o_strobe(o_strobe), .o_hit(o_hit), .o_event(o_event),
    .o_msg_type(o_msg_type), .o_version(o_version), .o_hdr_ofs(o_hdr_ofs)
  );
endmodule

// File: tb/tb_ptp_event_classifier.sv
module tb_ptp_event_classifier;
  localparam int CLK_PERIOD = 10;
  localparam int OFFW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic o_strobe, o_hit, o_event;
  logic [3:0] o_msg_type, o_version;
  logic [OFFW-1:0] o_hdr_ofs;

  always #(CLK_PERIOD/2) clk = ~clk;

  ptp_event_classifier #(.OFFW(OFFW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .o_strobe(o_strobe), .o_hit(o_hit), .o_event(o_event),
    .o_msg_type(o_msg_type), .o_version(o_version), .o_hdr_ofs(o_hdr_ofs)
  );

  // encap: 0 raw PTP, 1 IPv4, 2 IPv6, 3 MPLS+IPv4, 4 MPLS+IPv6, 5 other EtherType
  typedef struct packed {
    logic [2:0]  encap;
    logic [1:0]  vlans;
    logic        svc;
    logic [3:0]  ihl;
    logic [1:0]  labels;
    logic        bad;
    logic [15:0] port;
    logic [3:0]  ver;
    logic [3:0]  mt;
    logic        hit;
    logic [9:0]  ofs;
    logic        ev;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd2, 4'h0, 1'b1, 10'd14, 1'b1},
    '{3'd0, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd2, 4'hB, 1'b1, 10'd14, 1'b0},
    '{3'd0, 2'd1, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd2, 4'h1, 1'b1, 10'd18, 1'b1},
    '{3'd0, 2'd2, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd1, 4'h0, 1'b1, 10'd22, 1'b1},
    '{3'd0, 2'd0, 1'b1, 4'd5, 2'd0, 1'b0, 16'd0,    4'd2, 4'h8, 1'b1, 10'd36, 1'b0},
    '{3'd1, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd319,  4'd2, 4'h0, 1'b1, 10'd42, 1'b1},
    '{3'd1, 2'd1, 1'b0, 4'd6, 2'd0, 1'b0, 16'd320,  4'd2, 4'hB, 1'b1, 10'd50, 1'b0},
    '{3'd2, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd319,  4'd2, 4'h1, 1'b1, 10'd62, 1'b1},
    '{3'd3, 2'd0, 1'b0, 4'd5, 2'd1, 1'b0, 16'd319,  4'd2, 4'h0, 1'b1, 10'd46, 1'b1},
    '{3'd4, 2'd0, 1'b0, 4'd5, 2'd2, 1'b0, 16'd320,  4'd2, 4'h8, 1'b1, 10'd70, 1'b0},
    '{3'd1, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd1234, 4'd2, 4'h0, 1'b0, 10'd0,  1'b0},
    '{3'd0, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd3, 4'h0, 1'b0, 10'd0,  1'b0},
    '{3'd5, 2'd0, 1'b0, 4'd5, 2'd0, 1'b0, 16'd0,    4'd2, 4'h0, 1'b0, 10'd0,  1'b0},
    '{3'd1, 2'd0, 1'b0, 4'd5, 2'd0, 1'b1, 16'd319,  4'd2, 4'h0, 1'b0, 10'd0,  1'b0},
    '{3'd2, 2'd0, 1'b0, 4'd5, 2'd0, 1'b1, 16'd319,  4'd2, 4'h0, 1'b0, 10'd0,  1'b0},
    '{3'd1, 2'd1, 1'b1, 4'd5, 2'd0, 1'b0, 16'd319,  4'd2, 4'h1, 1'b1, 10'd68, 1'b1}
  };

  int checks = 0;
  int errors = 0;
  int sent = 0;
  int strobe_cnt = 0;
  int strobe_at = -1;
  logic [7:0] fr [256];
  int n = 0;

  always @(negedge clk) begin
    if (o_strobe) begin
      strobe_cnt = strobe_cnt + 1;
      strobe_at = sent;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic push(input logic [7:0] b);
    fr[n] = b;
    n++;
  endtask

  task automatic build(input vec_t v);
    n = 0;
    for (int i = 0; i < 12; i++) push(8'h10 + 8'(i));
    if (v.svc) begin
      push(8'h88); push(8'hA8); push(8'h00); push(8'h05);
      push(8'h88); push(8'hE7); push(8'h00); push(8'h00); push(8'h00); push(8'h01);
      for (int i = 0; i < 12; i++) push(8'h40 + 8'(i));
    end
    for (int i = 0; i < int'(v.vlans); i++) begin
      push(8'h81); push(8'h00); push(8'h00); push(8'h07);
    end
    case (v.encap)
      3'd0: begin push(8'h88); push(8'hF7); end
      3'd1: begin push(8'h08); push(8'h00); end
      3'd2: begin push(8'h86); push(8'hDD); end
      3'd3, 3'd4: begin push(8'h88); push(8'h47); end
      default: begin push(8'h08); push(8'h06); end
    endcase
    if (v.encap == 3'd3 || v.encap == 3'd4) begin
      for (int l = 0; l < int'(v.labels); l++) begin
        push(8'h00); push(8'h10);
        push((l == int'(v.labels) - 1) ? 8'h01 : 8'h00);
        push(8'h40);
      end
    end
    if (v.encap == 3'd1 || v.encap == 3'd3) begin
      for (int i = 0; i < int'(v.ihl) * 4; i++)
        push(i == 0 ? {4'h4, v.ihl} : i == 9 ? (v.bad ? 8'd6 : 8'd17) :
             i == 8 ? 8'd64 : 8'h00);
    end
    if (v.encap == 3'd2 || v.encap == 3'd4) begin
      for (int i = 0; i < 40; i++)
        push(i == 0 ? 8'h60 : i == 6 ? (v.bad ? 8'd6 : 8'd17) :
             i == 7 ? 8'd64 : 8'h00);
    end
    if (v.encap >= 3'd1 && v.encap <= 3'd4) begin
      push(8'h01); push(8'h3F); push(v.port[15:8]); push(v.port[7:0]);
      push(8'h00); push(8'h30); push(8'h00); push(8'h00);
    end
    push({4'h0, v.mt});
    push({4'h0, v.ver});
    for (int i = 0; i < 38; i++) push(8'hA5);
  endtask

  task automatic drive(input logic [7:0] b, input logic sof);
    @(negedge clk);
    in_valid = 1'b1;
    in_data = b;
    in_sof = sof;
    @(posedge clk);
    sent++;
  endtask

  task automatic idle(input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof = 1'b0;
      @(posedge clk);
    end
  endtask

  task automatic send(input int upto, input bit gaps);
    sent = 0;
    strobe_cnt = 0;
    strobe_at = -1;
    for (int i = 0; i < upto; i++) begin
      if (gaps && (i % 3 == 1)) idle(2);
      drive(fr[i], i == 0);
    end
  endtask

  function automatic string req_of(input vec_t v);
    if (v.ver != 4'd1 && v.ver != 4'd2) return "R9";
    if (v.encap == 3'd5) return "R12";
    if (v.bad) return (v.encap == 3'd2) ? "R6" : "R5";
    if (v.encap != 3'd0 && v.port != 16'd319 && v.port != 16'd320) return "R7";
    if (v.svc) return "R4";
    if (v.vlans != 2'd0) return "R3";
    if (v.encap >= 3'd3) return "R8";
    if (v.encap == 3'd1) return "R5";
    if (v.encap == 3'd2) return "R6";
    return "R2";
  endfunction

  task automatic verify(input vec_t v, input string req);
    idle(3);
    @(negedge clk);
    chk(o_hit == v.hit, req, "hit", int'(o_hit), int'(v.hit));
    chk(strobe_cnt == (v.hit ? 1 : 0), "R10", "strobe count", strobe_cnt, v.hit ? 1 : 0);
    if (v.hit) begin
      chk(o_hdr_ofs == v.ofs, req, "offset", int'(o_hdr_ofs), int'(v.ofs));
      chk(o_msg_type == v.mt, "R2", "msg type", int'(o_msg_type), int'(v.mt));
      chk(o_version == v.ver, "R2", "version", int'(o_version), int'(v.ver));
      chk(o_event == v.ev, (v.encap == 3'd0) ? "R14" : "R7", "event",
          int'(o_event), int'(v.ev));
      chk(strobe_at == int'(v.ofs) + 2, "R10", "strobe byte count",
          strobe_at, int'(v.ofs) + 2);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(o_hit == 1'b0, "R1", "hit after reset", int'(o_hit), 0);
    chk(o_strobe == 1'b0, "R1", "strobe after reset", int'(o_strobe), 0);
    idle(3);
    @(negedge clk);
    chk(o_hit == 1'b0, "R1", "hit while idle", int'(o_hit), 0);

    // table walk; odd entries carry idle gaps (R11)
    for (int k = 0; k < NV; k++) begin
      build(VECS[k]);
      send(n, k % 2 == 1);
      verify(VECS[k], (k % 2 == 1) ? "R11" : req_of(VECS[k]));
    end

    // R13: truncated IPv4 frame, then a raw PTP frame
    build(VECS[5]);
    send(20, 1'b0);
    build(VECS[0]);
    send(n, 1'b0);
    verify(VECS[0], "R13");

    // R10: hold across idle time, clear after next start-of-frame byte
    idle(20);
    @(negedge clk);
    chk(o_hit == 1'b1, "R10", "hit held while idle", int'(o_hit), 1);
    chk(o_hdr_ofs == 10'd14, "R10", "offset held", int'(o_hdr_ofs), 14);
    drive(8'h10, 1'b1);
    @(negedge clk);
    chk(o_hit == 1'b0, "R10", "hit cleared after sof", int'(o_hit), 0);
    idle(2);

    // R12 after a hit: other EtherType gives no strobe
    build(VECS[12]);
    send(n, 1'b1);
    verify(VECS[12], "R12");

    report();
  end
endmodule